// File: doc/BRIEF.md
# Peripheral-Requested Burst DMA Channel

This block is one DMA channel that moves whole 32-bit words between a narrow external peripheral and a word-wide memory port. A peripheral starts a transfer by driving a request level that is asynchronous to the channel clock. The channel synchronizes that level and measures how long it stays high. Only a pulse whose width falls inside a bounded window starts a burst.

A burst moves a configured number of words. Each word is built from, or split into, several peripheral accesses: four in byte mode and two in halfword mode, packed little-endian. Memory transfers use a request/grant handshake. The peripheral side of a word never overlaps a pending memory transfer.

The configuration inputs are sampled when a burst starts. A length field that does not match the word count is refused and raises a flag. A request held too long raises a sticky flag and is dropped.

Top module: `burst_dma_chan`

## Requirements
- R1: After reset, every output is 0: `per_rd`, `per_wr`, `mem_req`, `done`, `err_long` and `err_cfg`. The request input passes through a two-stage synchronizer before any logic uses it.
- R2: The synchronized request must stay high for between 4 and 20 clock cycles, inclusive. Such a pulse starts exactly one burst. No peripheral or memory activity begins while the request is still high.
- R3: When the request stays high for more than 20 cycles, `err_long` is set and no burst starts. `err_long` stays set through later bursts and is cleared only by reset.
- R4: A pulse shorter than 4 cycles starts nothing and changes no flag.
- R5: A burst is refused when `cfg_burst` is 0 or when `cfg_len` is not equal to `cfg_burst`×4. A refused burst makes no access and sets `err_cfg`. The next accepted start clears `err_cfg`.
- R6: Byte mode is `cfg_wide`=0. Each word takes exactly four peripheral accesses, carried on `per_*data[7:0]`. The first access is word bits 7:0 and the later accesses are successively higher bytes. In this mode `per_wdata[15:8]` is 0.
- R7: Halfword mode is `cfg_wide`=1. Each word takes exactly two peripheral accesses. The first access is word bits 15:0 and the second is bits 31:16.
- R8: `cfg_to_mem`=1 moves data from the peripheral to memory: the peripheral reads come first, then one memory write with `mem_we`=1. `cfg_to_mem`=0 moves data from memory to the peripheral: one memory read with `mem_we`=0 comes first, then the peripheral writes. `per_rd` and `per_wr` are never both high.
- R9: Once `mem_req` rises, it stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_gnt` is seen. Word i of a burst uses address `cfg_base`+4·i.
- R10: No peripheral access happens while `mem_req` is high. The peripheral accesses for the next word start only after the previous word's grant.
- R11: `done` pulses for one cycle after the last word of a burst completes. The cycle after `done`, the channel is idle.
- R12: A request that rises while a burst is in progress is ignored, even if it is still high after the burst ends. Detection re-arms only after the synchronized request has been seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_req_a | input | 1 | Asynchronous transfer request from the peripheral |
| cfg_burst | input | BURST_W | Words per burst |
| cfg_len | input | LEN_W | Buffer length in bytes; must be cfg_burst×4 |
| cfg_wide | input | 1 | 0: byte peripheral, 1: halfword peripheral |
| cfg_to_mem | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| cfg_base | input | AW | Memory byte address of word 0 |
| per_rd | output | 1 | Peripheral read strobe, one access per cycle |
| per_wr | output | 1 | Peripheral write strobe, one access per cycle |
| per_wdata | output | 16 | Data for a peripheral write |
| per_rdata | input | 16 | Peripheral read data, valid in the `per_rd` cycle |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid in the grant cycle |
| mem_gnt | input | 1 | Grant; completes the transfer in the same cycle |
| done | output | 1 | One-cycle burst completion pulse |
| err_long | output | 1 | Sticky over-long request flag |
| err_cfg | output | 1 | Length/burst mismatch flag |

## Verification
Two functions can coincide:
- request detection, which runs on its own clock-by-clock measurement, and the burst engine, which is still moving words;
- a new request edge, which can land while words are being granted, or right in the `done` cycle.

The bench provokes this with slow memory grants. During one burst it raises a second request that drops mid-burst; during another it raises a request that stays high well past `done`. In both cases it judges the outcome at the ports. Only one `done` may appear, exactly one burst's worth of accesses, and no `err_long` even though the stale request stayed high longer than 20 cycles. A later clean pulse must then be serviced.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PER  = 2'd1,
    ST_MEM  = 2'd2,
    ST_DONE = 2'd3
  } bdc_state_e;

  // buffer length must cover exactly the burst in whole words
  function automatic logic len_matches(input logic [31:0] words, input logic [31:0] bytes);
    return (words != 32'd0) && (bytes == (words << 2));
  endfunction

  // index of the last peripheral access inside one word
  function automatic logic [1:0] last_beat_of(input logic wide);
    return wide ? 2'd1 : 2'd3;
  endfunction

  // little-endian lane insert: beat 0 lands in the lowest lane
  function automatic logic [31:0] lane_insert(input logic [31:0] w, input logic [15:0] d,
                                              input logic [1:0] beat, input logic wide);
    logic [31:0] r;
    r = w;
    if (wide) r[{beat[0], 4'b0000} +: 16] = d;
    else      r[{beat, 3'b000} +: 8]      = d[7:0];
    return r;
  endfunction

  function automatic logic [15:0] lane_extract(input logic [31:0] w, input logic [1:0] beat,
                                               input logic wide);
    if (wide) return w[{beat[0], 4'b0000} +: 16];
    return {8'h00, w[{beat, 3'b000} +: 8]};
  endfunction

endpackage

// File: rtl/bdc_req_qual.sv
module bdc_req_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HI      = 4,
  parameter int MAX_HI      = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  input  logic busy,
  output logic qual,
  output logic too_long
);
  localparam int CW = $clog2(MAX_HI + 2);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_s, req_q, active;
  logic [CW-1:0]          hi_cnt;
  logic                   rise_idle, fall_seen, in_window, over_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], req_async};
  end

  assign req_s     = sync_q[SYNC_STAGES-1];
  assign rise_idle = req_s && !req_q && !busy;
  assign fall_seen = active && !req_s;
  assign in_window = (hi_cnt >= CW'(MIN_HI)) && (hi_cnt <= CW'(MAX_HI));
  assign over_now  = active && req_s && (hi_cnt == CW'(MAX_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      active   <= 1'b0;
      hi_cnt   <= '0;
      qual     <= 1'b0;
      too_long <= 1'b0;
    end else begin
      req_q    <= req_s;
      qual     <= fall_seen && in_window;
      too_long <= over_now;
      if (rise_idle) begin
        active <= 1'b1;
        hi_cnt <= CW'(1);
      end else if (active) begin
        if (!req_s) active <= 1'b0;
        else if (hi_cnt <= CW'(MAX_HI)) hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

  // R12: a start is only ever signalled while the engine is idle
  p_qual_idle_r12: assert property (@(posedge clk) disable iff (!rst_n) qual |-> !busy);
  // R4/R3: one pulse cannot both qualify and overrun
  p_qual_excl_r4: assert property (@(posedge clk) disable iff (!rst_n) !(qual && too_long));
  // R2: qualification follows the falling edge of the synchronized request
  p_qual_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    qual |-> !req_q);
endmodule

// File: rtl/bdc_lane_pack.sv
module bdc_lane_pack
  import bdc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        step,
  input  logic        capture,
  input  logic        load,
  input  logic [31:0] load_word,
  input  logic [15:0] per_in,
  input  logic        wide,
  output logic [31:0] word,
  output logic [15:0] per_out,
  output logic        last_beat
);
  logic [1:0] beat;

  assign last_beat = (beat == last_beat_of(wide));
  assign per_out   = lane_extract(word, beat, wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat <= 2'd0;
      word <= '0;
    end else begin
      if (start)     beat <= 2'd0;
      else if (step) beat <= last_beat ? 2'd0 : beat + 2'd1;
      if (load)                word <= load_word;
      else if (step && capture) word <= lane_insert(word, per_in, beat, wide);
    end
  end

  // R7: halfword mode never walks past its second lane
  p_beat_half_r7: assert property (@(posedge clk) disable iff (!rst_n) wide |-> !beat[1]);
endmodule

// File: rtl/burst_dma_chan.sv
module burst_dma_chan
  import bdc_pkg::*;
#(
  parameter int BURST_W     = 5,
  parameter int LEN_W       = 8,
  parameter int AW          = 32,
  parameter int SYNC_STAGES = 2,
  parameter int REQ_MIN     = 4,
  parameter int REQ_MAX     = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_req_a,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               cfg_wide,
  input  logic               cfg_to_mem,
  input  logic [AW-1:0]      cfg_base,
  output logic               per_rd,
  output logic               per_wr,
  output logic [15:0]        per_wdata,
  input  logic [15:0]        per_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata,
  input  logic               mem_gnt,
  output logic               done,
  output logic               err_long,
  output logic               err_cfg
);
  localparam int PADW = AW - BURST_W - 2;

  bdc_state_e         st;
  logic               qual, too_long, busy, cfg_good, start_ok;
  logic               per_step, mem_fire, last_beat, last_word;
  logic [BURST_W-1:0] burst_q, word_idx;
  logic               wide_q, to_mem_q;
  logic [AW-1:0]      base_q;
  logic [31:0]        word;

  assign busy     = (st != ST_IDLE);
  assign cfg_good = len_matches(32'(cfg_burst), 32'(cfg_len));
  assign start_ok = qual && cfg_good;
  assign per_step = (st == ST_PER);
  assign mem_fire = (st == ST_MEM) && mem_gnt;
  assign last_word = (word_idx == burst_q - 1'b1);

  assign per_rd    = per_step && to_mem_q;
  assign per_wr    = per_step && !to_mem_q;
  assign mem_req   = (st == ST_MEM);
  assign mem_we    = to_mem_q;
  assign mem_addr  = base_q + {{PADW{1'b0}}, word_idx, 2'b00};
  assign mem_wdata = word;
  assign done      = (st == ST_DONE);

  bdc_req_qual #(
    .SYNC_STAGES(SYNC_STAGES), .MIN_HI(REQ_MIN), .MAX_HI(REQ_MAX)
  ) u_qual (
    .clk(clk), .rst_n(rst_n), .req_async(xfer_req_a), .busy(busy),
    .qual(qual), .too_long(too_long)
  );

  bdc_lane_pack u_pack (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .step(per_step),
    .capture(to_mem_q), .load(mem_fire && !to_mem_q), .load_word(mem_rdata),
    .per_in(per_rdata), .wide(wide_q), .word(word), .per_out(per_wdata),
    .last_beat(last_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_long <= 1'b0;
    else if (too_long) err_long <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      burst_q  <= '0;
      word_idx <= '0;
      wide_q   <= 1'b0;
      to_mem_q <= 1'b0;
      base_q   <= '0;
      err_cfg  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (qual) begin
            if (cfg_good) begin
              burst_q  <= cfg_burst;
              wide_q   <= cfg_wide;
              to_mem_q <= cfg_to_mem;
              base_q   <= cfg_base;
              word_idx <= '0;
              err_cfg  <= 1'b0;
              st       <= cfg_to_mem ? ST_PER : ST_MEM;
            end else begin
              err_cfg <= 1'b1;
            end
          end
        end
        ST_PER: begin
          if (last_beat) begin
            if (to_mem_q) st <= ST_MEM;
            else if (last_word) st <= ST_DONE;
            else begin
              word_idx <= word_idx + 1'b1;
              st       <= ST_MEM;
            end
          end
        end
        ST_MEM: begin
          if (mem_gnt) begin
            if (!to_mem_q) st <= ST_PER;
            else if (last_word) st <= ST_DONE;
            else begin
              word_idx <= word_idx + 1'b1;
              st       <= ST_PER;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8: peripheral strobes are exclusive
  p_excl_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n) !(per_rd && per_wr));
  // R9: an ungranted memory request holds its command
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R10: peripheral side waits for the memory side
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !(per_rd || per_wr));
  // R11: done is one cycle and followed by idle
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !mem_req && !per_rd && !per_wr));
  // R3: the overrun flag is sticky
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n) err_long |=> err_long);
  // R5: a refused start makes no access and flags the error
  p_bad_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !cfg_good) |=> (err_cfg && !mem_req && !per_rd && !per_wr));
endmodule

// File: tb/burst_dma_chan_tb.sv
`timescale 1ns/1ps
module burst_dma_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_req_a = 1'b0;
  logic [4:0]  cfg_burst = '0;
  logic [7:0]  cfg_len = '0;
  logic        cfg_wide = 1'b0, cfg_to_mem = 1'b0;
  logic [31:0] cfg_base = '0;
  logic        per_rd, per_wr, mem_req, mem_we, mem_gnt, done, err_long, err_cfg;
  logic [15:0] per_wdata, per_rdata;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0, errors = 0;
  logic [3:0] gdly = '0;
  logic       clr = 1'b0;
  logic [3:0] gcnt;
  int rd_n, pw_n, mt_n, done_n, ovl_n, stab_n;
  logic [15:0] pw_log [64];
  logic [31:0] ma_log [64];
  logic [31:0] md_log [64];
  logic        pend;
  logic [31:0] pa, pd;

  always #2.5 clk = ~clk;

  burst_dma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_req_a(xfer_req_a), .cfg_burst(cfg_burst),
    .cfg_len(cfg_len), .cfg_wide(cfg_wide), .cfg_to_mem(cfg_to_mem), .cfg_base(cfg_base),
    .per_rd(per_rd), .per_wr(per_wr), .per_wdata(per_wdata), .per_rdata(per_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .done(done), .err_long(err_long),
    .err_cfg(err_cfg)
  );

  function automatic logic [15:0] ppat(input int i);
    return 16'h3A5C ^ 16'(i * 16'h0F13);
  endfunction
  function automatic logic [31:0] mpat(input logic [31:0] a);
    return (a * 32'h0101_0007) ^ 32'hC3A5_96E1;
  endfunction

  assign per_rdata = ppat(rd_n);
  assign mem_rdata = mpat(mem_addr);
  assign mem_gnt   = mem_req && (gcnt >= gdly);

  // peripheral and memory models plus observation counters
  always @(posedge clk) begin
    if (clr) begin
      rd_n <= 0; pw_n <= 0; mt_n <= 0; done_n <= 0; ovl_n <= 0; stab_n <= 0;
      gcnt <= '0; pend <= 1'b0;
    end else begin
      gcnt <= (mem_req && !mem_gnt) ? gcnt + 4'd1 : 4'd0;
      if (per_rd) rd_n <= rd_n + 1;
      if (per_wr) begin pw_log[pw_n[5:0]] <= per_wdata; pw_n <= pw_n + 1; end
      if (mem_req && mem_gnt) begin
        ma_log[mt_n[5:0]] <= mem_addr; md_log[mt_n[5:0]] <= mem_wdata; mt_n <= mt_n + 1;
      end
      if (done) done_n <= done_n + 1;
      if (mem_req && (per_rd || per_wr)) ovl_n <= ovl_n + 1;
      if (pend && (!mem_req || mem_addr != pa || (mem_we && mem_wdata != pd))) stab_n <= stab_n + 1;
      pend <= mem_req && !mem_gnt;
      pa <= mem_addr; pd <= mem_wdata;
    end
  end

  task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; xfer_req_a = 1'b0;
    clr = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  // drive a request pulse; returns how many cycles showed activity while high
  task automatic pulse(input int len, output int act);
    act = 0;
    xfer_req_a = 1'b1;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if (per_rd || per_wr || mem_req) act++;
    end
    xfer_req_a = 1'b0;
  endtask

  task automatic set_cfg(input logic w, input logic tm, input logic [4:0] b,
                         input logic [7:0] l, input logic [31:0] base);
    cfg_wide = w; cfg_to_mem = tm; cfg_burst = b; cfg_len = l; cfg_base = base;
  endtask

  typedef struct packed {
    logic       wide;
    logic       to_mem;
    logic [4:0] burst;
    logic [7:0] len;
    logic [3:0] gdly;
    logic [5:0] hold;
    logic       svc;
    logic       cfgbad;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b1, 5'd2, 8'd8,  4'd0, 6'd6,  1'b1, 1'b0},
    '{1'b1, 1'b1, 5'd3, 8'd12, 4'd2, 6'd4,  1'b1, 1'b0},
    '{1'b0, 1'b0, 5'd2, 8'd8,  4'd1, 6'd20, 1'b1, 1'b0},
    '{1'b1, 1'b0, 5'd1, 8'd4,  4'd3, 6'd10, 1'b1, 1'b0},
    '{1'b0, 1'b1, 5'd1, 8'd4,  4'd0, 6'd3,  1'b0, 1'b0},
    '{1'b1, 1'b1, 5'd2, 8'd7,  4'd0, 6'd8,  1'b0, 1'b1},
    '{1'b0, 1'b0, 5'd4, 8'd16, 4'd0, 6'd5,  1'b1, 1'b0},
    '{1'b0, 1'b1, 5'd0, 8'd0,  4'd0, 6'd6,  1'b0, 1'b1}
  };

  task automatic check_data(input vec_t v, input logic [31:0] base);
    int beats;
    logic [31:0] exp;
    beats = v.wide ? 2 : 4;
    for (int i = 0; i < int'(v.burst); i++) begin
      chk("R9 address", ma_log[i] == base + 32'(4 * i), ma_log[i], base + 32'(4 * i));
      if (v.to_mem) begin
        exp = '0;
        for (int k = 0; k < beats; k++) begin
          if (v.wide) exp = exp | (32'(ppat(i * 2 + k)) << (16 * k));
          else        exp = exp | (32'(ppat(i * 4 + k) & 16'h00FF) << (8 * k));
        end
        chk(v.wide ? "R7 pack" : "R6 pack", md_log[i] == exp, md_log[i], exp);
      end else begin
        for (int k = 0; k < beats; k++) begin
          if (v.wide) exp = (mpat(base + 32'(4 * i)) >> (16 * k)) & 32'hFFFF;
          else        exp = (mpat(base + 32'(4 * i)) >> (8 * k)) & 32'hFF;
          chk(v.wide ? "R7 unpack" : "R6 unpack", 32'(pw_log[i * beats + k]) == exp,
              32'(pw_log[i * beats + k]), exp);
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int act;
    logic exp_cfg;
    logic [31:0] base;
    do_reset();
    // R1 reset state
    chk("R1 reset outputs", {per_rd, per_wr, mem_req, done, err_long, err_cfg} == 6'b0,
        32'({per_rd, per_wr, mem_req, done, err_long, err_cfg}), 32'd0);

    exp_cfg = 1'b0;
    for (int n = 0; n < NV; n++) begin
      base = 32'h1000_0000 + 32'(n * 256);
      set_cfg(VT[n].wide, VT[n].to_mem, VT[n].burst, VT[n].len, base);
      gdly = VT[n].gdly;
      clear_logs();
      pulse(int'(VT[n].hold), act);
      repeat (300) @(negedge clk);
      if (VT[n].hold >= 6'd4 && VT[n].hold <= 6'd20) exp_cfg = VT[n].cfgbad;
      chk("R2 quiet while request high", act == 0, 32'(act), 32'd0);
      chk("R11 done count", done_n == (VT[n].svc ? 1 : 0), 32'(done_n), VT[n].svc ? 32'd1 : 32'd0);
      chk("R8 memory transfers", mt_n == (VT[n].svc ? int'(VT[n].burst) : 0), 32'(mt_n),
          VT[n].svc ? 32'(VT[n].burst) : 32'd0);
      if (VT[n].to_mem)
        chk(VT[n].wide ? "R7 read count" : "R6 read count",
            rd_n == (VT[n].svc ? int'(VT[n].burst) * (VT[n].wide ? 2 : 4) : 0), 32'(rd_n),
            VT[n].svc ? 32'(int'(VT[n].burst) * (VT[n].wide ? 2 : 4)) : 32'd0);
      else
        chk(VT[n].wide ? "R7 write count" : "R6 write count",
            pw_n == (VT[n].svc ? int'(VT[n].burst) * (VT[n].wide ? 2 : 4) : 0), 32'(pw_n),
            VT[n].svc ? 32'(int'(VT[n].burst) * (VT[n].wide ? 2 : 4)) : 32'd0);
      chk("R5 err_cfg", err_cfg == exp_cfg, 32'(err_cfg), 32'(exp_cfg));
      chk("R4 no overrun flag", err_long == 1'b0, 32'(err_long), 32'd0);
      chk("R10 no overlap", ovl_n == 0, 32'(ovl_n), 32'd0);
      chk("R9 hold until grant", stab_n == 0, 32'(stab_n), 32'd0);
      if (VT[n].svc) check_data(VT[n], base);
    end

    // R3: over-long pulse flags and is dropped; flag is sticky until reset
    do_reset();
    set_cfg(1'b0, 1'b1, 5'd1, 8'd4, 32'h2000_0000); gdly = 4'd0;
    clear_logs();
    pulse(21, act);
    repeat (100) @(negedge clk);
    chk("R3 long flag set", err_long == 1'b1, 32'(err_long), 32'd1);
    chk("R3 long not serviced", (rd_n == 0) && (done_n == 0), 32'(rd_n + done_n), 32'd0);
    pulse(20, act);
    repeat (100) @(negedge clk);
    chk("R3 later burst serviced", done_n == 1 && rd_n == 4, 32'(done_n), 32'd1);
    chk("R3 flag sticky", err_long == 1'b1, 32'(err_long), 32'd1);
    do_reset();
    chk("R3 cleared by reset", err_long == 1'b0, 32'(err_long), 32'd0);

    // R12: requests rising mid-burst are ignored, even if held past done
    set_cfg(1'b0, 1'b1, 5'd4, 8'd16, 32'h3000_0000); gdly = 4'd10;
    clear_logs();
    pulse(6, act);
    repeat (12) @(negedge clk);
    pulse(8, act);
    repeat (300) @(negedge clk);
    chk("R12 mid-burst pulse ignored", done_n == 1 && mt_n == 4, 32'(done_n), 32'd1);
    clear_logs();
    pulse(6, act);
    repeat (10) @(negedge clk);
    pulse(120, act);
    repeat (300) @(negedge clk);
    chk("R12 held request not serviced", done_n == 1 && mt_n == 4, 32'(done_n), 32'd1);
    chk("R12 held request no overrun", err_long == 1'b0, 32'(err_long), 32'd0);
    clear_logs();
    pulse(7, act);
    repeat (300) @(negedge clk);
    chk("R12 re-armed after low", done_n == 1 && rd_n == 16, 32'(rd_n), 32'd16);
    chk("R10 no overlap slow grant", ovl_n == 0, 32'(ovl_n), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule